// File: doc/BRIEF.md
# Flit-to-Frame Link Packer with CRC Check

This block sits between a link layer that produces 65-bit flits and a physical side that moves fixed-width words. Each flit carries 64 payload bits and one type bit that tells packet data apart from link commands. The transmit path gathers sixteen flits into one frame, adds two credit sideband bits and a 14-bit CRC, and sends the 1056-bit frame as a run of equal-width words. Data and command flits can appear in any order inside a frame. Once a frame has begun, every slot that finds no flit waiting is filled with an idle command flit, so frames always close in bounded time.

The receive path takes the same word stream, rebuilds the frame and recomputes the CRC. It then presents the sixteen flits and the credit bits for one cycle, together with an error flag if the check failed. A long packet simply occupies as many consecutive frames as it needs. Splitting packets into flits, replay storage and lane handling are done elsewhere.

Top module: `ltp_framer`

## Requirements
- R1: While rst_ni is low and right after it, tx_word_valid_o, rx_frame_valid_o and rx_crc_error_o are 0 and tx_flit_ready_o is 1.
- R2: A frame is laid out from its most significant bit as slot 0 through slot 15 (65 bits each, in acceptance order), then the 2 credit bits, then the 14-bit CRC. It is sent as 16 words of 66 bits, most significant word first.
- R3: After slot 0 of a frame is filled, any cycle with space and no valid flit fills the next slot with an idle flit: type bit 1 and payload IDLE_PAYLOAD (default all zeros).
- R4: With no flit offered and no frame in progress, no output word is produced.
- R5: The CRC is computed over the 1042 bits of slots plus credit, most significant bit first. The seed is all ones, the polynomial is CRC_POLY (default 14'h202B, shift left, feedback from the top bit) and there is no final inversion.
- R6: The credit field holds the value of tx_credit_i in the cycle in which slot 15 is filled.
- R7: In the cycle after slot 15 fills, tx_flit_ready_o is low. A flit offered then is held off and enters a later frame, and no flit is lost or duplicated.
- R8: Each frame's 16 words leave on consecutive cycles, with no gap inside a frame.
- R9: One cycle after the 16th word of a frame is received, rx_frame_valid_o pulses for one cycle with the 16 flits and the credit bits.
- R10: rx_crc_error_o pulses with rx_frame_valid_o exactly when the recomputed CRC differs from the received one. Otherwise it stays 0.
- R11: The type bit (bit 64 of a flit, 1 = command) passes through unchanged, and data and command flits may be mixed in any order within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_flit_valid_i | input | 1 | A flit is offered |
| tx_flit_i | input | 65 | Flit: bit 64 is the type, bits 63:0 are the payload |
| tx_flit_ready_o | output | 1 | The offered flit is accepted on this edge |
| tx_credit_i | input | 2 | Credit sideband value for the frame being closed |
| tx_word_valid_o | output | 1 | Output word is valid |
| tx_word_o | output | WORD_W (66) | Output frame word |
| rx_word_valid_i | input | 1 | Received word is valid |
| rx_word_i | input | WORD_W (66) | Received frame word |
| rx_frame_valid_o | output | 1 | Single-cycle pulse: a rebuilt frame is presented |
| rx_crc_error_o | output | 1 | CRC mismatch on the presented frame |
| rx_flits_o | output | 1040 | Sixteen received flits, slot 0 at the top |
| rx_credit_o | output | 2 | Received credit bits |

## Verification
The hardest case to reach from the ports is a received frame that is corrupted, since the transmit path always produces correct CRCs. The bench loops the transmit words back into the receiver through an XOR mask. For chosen frame numbers it flips one bit of the fourth word and expects the error pulse on exactly those frames. Idle fill and the one-cycle ready drop at the end of a frame also depend on timing. Directed short bursts and random gaps in the flit stream bring both about, and a model that follows the handshake works out the expected slot contents.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
  localparam int PAY_W     = 64;
  localparam int FLIT_W    = PAY_W + 1;
  localparam int NUM_SLOTS = 16;
  localparam int CRC_W     = 14;
  localparam int CRD_W     = 2;
  localparam int SLOTS_W   = FLIT_W * NUM_SLOTS;
  localparam int MSG_W     = SLOTS_W + CRD_W;
  localparam int FRAME_W   = MSG_W + CRC_W;

  typedef logic [FLIT_W-1:0] flit_t;
  typedef logic [CRC_W-1:0]  crc_t;

  localparam crc_t CRC_SEED = '1;

  function automatic crc_t crc_bit(crc_t c, logic b, crc_t poly);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  function automatic crc_t crc_flit(crc_t c, flit_t f, crc_t poly);
    crc_t r;
    r = c;
    for (int i = FLIT_W-1; i >= 0; i--) r = crc_bit(r, f[i], poly);
    return r;
  endfunction

  function automatic crc_t crc_credit(crc_t c, logic [CRD_W-1:0] k, crc_t poly);
    crc_t r;
    r = c;
    for (int i = CRD_W-1; i >= 0; i--) r = crc_bit(r, k[i], poly);
    return r;
  endfunction
endpackage

// File: rtl/ltp_tx_assembler.sv
module ltp_tx_assembler
  import ltp_pkg::*;
#(
  parameter crc_t             CRC_POLY     = 14'h202B,
  parameter logic [PAY_W-1:0] IDLE_PAYLOAD = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  flit_t              in_flit_i,
  output logic               in_ready_o,
  input  logic [CRD_W-1:0]   credit_i,
  output logic               frame_valid_o,
  output logic [FRAME_W-1:0] frame_o,
  input  logic               frame_ready_i
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SLOTS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [SLOTS_W-1:0] slots_q;
  logic [CRD_W-1:0]   credit_q;
  crc_t               crc_q;

  logic  full, fill, fire, last;
  flit_t slot_flit;
  crc_t  crc_after;

  assign full      = (cnt_q == FULL_CNT);
  assign last      = (cnt_q == LAST_CNT);
  // once a frame is open, empty cycles become idle command flits
  assign fill      = !full && (in_valid_i || (cnt_q != '0));
  assign fire      = full && frame_ready_i;
  assign slot_flit = in_valid_i ? in_flit_i : {1'b1, IDLE_PAYLOAD};
  assign crc_after = crc_flit(crc_q, slot_flit, CRC_POLY);

  assign in_ready_o    = !full;
  assign frame_valid_o = full;
  assign frame_o       = {slots_q, credit_q, crc_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      slots_q  <= '0;
      credit_q <= '0;
      crc_q    <= CRC_SEED;
    end else if (fire) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
    end else if (fill) begin
      slots_q <= {slots_q[SLOTS_W-FLIT_W-1:0], slot_flit};
      cnt_q   <= cnt_q + 1'b1;
      if (last) begin
        credit_q <= credit_i;
        crc_q    <= crc_credit(crc_after, credit_i, CRC_POLY);
      end else begin
        crc_q <= crc_after;
      end
    end
  end
endmodule

// File: rtl/ltp_tx_serializer.sv
module ltp_tx_serializer
  import ltp_pkg::*;
#(
  parameter int WORD_W = 66
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ready_o,
  output logic               word_valid_o,
  output logic [WORD_W-1:0]  word_o
);
  localparam int NWORDS = FRAME_W / WORD_W;
  localparam int CNT_W  = $clog2(NWORDS + 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   left_q;

  // accept the next frame while the last word is on the wire
  assign ready_o      = (left_q <= CNT_W'(1));
  assign word_valid_o = (left_q != '0);
  assign word_o       = sreg_q[FRAME_W-1 -: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load_i && ready_o) begin
      sreg_q <= frame_i;
      left_q <= CNT_W'(NWORDS);
    end else if (left_q != '0) begin
      sreg_q <= sreg_q << WORD_W;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ltp_rx_deframer.sv
module ltp_rx_deframer
  import ltp_pkg::*;
#(
  parameter int   WORD_W   = 66,
  parameter crc_t CRC_POLY = 14'h202B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_valid_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               frame_valid_o,
  output logic               crc_error_o,
  output logic [SLOTS_W-1:0] flits_o,
  output logic [CRD_W-1:0]   credit_o
);
  localparam int NWORDS = FRAME_W / WORD_W;
  localparam int CNT_W  = $clog2(NWORDS);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(NWORDS - 1);

  logic [CNT_W-1:0]   wcnt_q;
  logic [FRAME_W-1:0] sreg_q;
  crc_t               crc_q;
  logic               vld_q, err_q;

  logic [FRAME_W-1:0] sreg_d;
  crc_t               crc_d;

  always_comb begin
    sreg_d = {sreg_q[FRAME_W-WORD_W-1:0], word_i};
    crc_d  = crc_q;
    // only message bits feed the CRC; the trailing CRC field is skipped
    for (int j = 0; j < WORD_W; j++) begin
      if ((int'(wcnt_q) * WORD_W + j) < MSG_W)
        crc_d = crc_bit(crc_d, word_i[WORD_W-1-j], CRC_POLY);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      sreg_q <= '0;
      crc_q  <= CRC_SEED;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      if (word_valid_i) begin
        sreg_q <= sreg_d;
        if (wcnt_q == LAST_W) begin
          wcnt_q <= '0;
          crc_q  <= CRC_SEED;
          vld_q  <= 1'b1;
          err_q  <= (crc_d != sreg_d[CRC_W-1:0]);
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
          crc_q  <= crc_d;
        end
      end
    end
  end

  assign frame_valid_o = vld_q;
  assign crc_error_o   = err_q;
  assign flits_o       = sreg_q[FRAME_W-1 -: SLOTS_W];
  assign credit_o      = sreg_q[CRC_W +: CRD_W];
endmodule

// File: rtl/ltp_framer.sv
module ltp_framer
  import ltp_pkg::*;
#(
  parameter int               WORD_W       = 66,
  parameter crc_t             CRC_POLY     = 14'h202B,
  parameter logic [PAY_W-1:0] IDLE_PAYLOAD = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_flit_valid_i,
  input  logic [FLIT_W-1:0]  tx_flit_i,
  output logic               tx_flit_ready_o,
  input  logic [CRD_W-1:0]   tx_credit_i,
  output logic               tx_word_valid_o,
  output logic [WORD_W-1:0]  tx_word_o,
  input  logic               rx_word_valid_i,
  input  logic [WORD_W-1:0]  rx_word_i,
  output logic               rx_frame_valid_o,
  output logic               rx_crc_error_o,
  output logic [SLOTS_W-1:0] rx_flits_o,
  output logic [CRD_W-1:0]   rx_credit_o
);
  generate
    if ((FRAME_W % WORD_W) != 0 || WORD_W < CRC_W || WORD_W >= FRAME_W) begin : g_bad_width
      $error("WORD_W must divide the frame and hold the CRC field");
    end
  endgenerate

  logic               asm_valid, ser_ready;
  logic [FRAME_W-1:0] asm_frame;

  ltp_tx_assembler #(
    .CRC_POLY    (CRC_POLY),
    .IDLE_PAYLOAD(IDLE_PAYLOAD)
  ) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (tx_flit_valid_i),
    .in_flit_i    (tx_flit_i),
    .in_ready_o   (tx_flit_ready_o),
    .credit_i     (tx_credit_i),
    .frame_valid_o(asm_valid),
    .frame_o      (asm_frame),
    .frame_ready_i(ser_ready)
  );

  ltp_tx_serializer #(
    .WORD_W(WORD_W)
  ) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (asm_valid),
    .frame_i     (asm_frame),
    .ready_o     (ser_ready),
    .word_valid_o(tx_word_valid_o),
    .word_o      (tx_word_o)
  );

  ltp_rx_deframer #(
    .WORD_W  (WORD_W),
    .CRC_POLY(CRC_POLY)
  ) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (rx_word_valid_i),
    .word_i       (rx_word_i),
    .frame_valid_o(rx_frame_valid_o),
    .crc_error_o  (rx_crc_error_o),
    .flits_o      (rx_flits_o),
    .credit_o     (rx_credit_o)
  );
endmodule

// File: rtl/ltp_framer_chk.sv
module ltp_framer_chk #(
  parameter int NWORDS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_flit_ready_o,
  input logic tx_word_valid_o,
  input logic rx_word_valid_i,
  input logic rx_frame_valid_o,
  input logic rx_crc_error_o
);
  localparam int RW = $clog2(NWORDS);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (tx_word_valid_o) run_q <= (run_q == RW'(NWORDS - 1)) ? '0 : run_q + 1'b1;
  end

  AST_WORD_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_word_valid_o |-> run_q == '0);  // R8

  AST_START_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_word_valid_o) |-> !$past(tx_flit_ready_o));  // R7

  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_valid_o |=> !rx_frame_valid_o);  // R9

  AST_FRAME_AFTER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_valid_o |-> $past(rx_word_valid_i));  // R9

  AST_ERR_WITH_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_crc_error_o |-> rx_frame_valid_o);  // R10
endmodule

bind ltp_framer ltp_framer_chk #(
  .NWORDS(ltp_pkg::FRAME_W / WORD_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .tx_flit_ready_o (tx_flit_ready_o),
  .tx_word_valid_o (tx_word_valid_o),
  .rx_word_valid_i (rx_word_valid_i),
  .rx_frame_valid_o(rx_frame_valid_o),
  .rx_crc_error_o  (rx_crc_error_o)
);

// File: tb/sim_ltp_framer.sv
module sim_ltp_framer;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 66;
  localparam int NW  = 1056 / W;
  localparam logic [13:0] POLY = 14'h202B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flit_valid = 1'b0;
  logic [64:0]   flit = '0;
  logic          ready;
  logic [1:0]    credit = '0;
  logic          wvalid;
  logic [W-1:0]  tx_word, rx_word;
  logic          fvalid, ferr;
  logic [1039:0] rx_flits;
  logic [1:0]    rx_credit;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1055:0] exp_q[$];
  logic [1039:0] acc = '0;
  int acc_n = 0;
  logic [1055:0] wbuf = '0;
  int wn = 0, frame_no = 0, rx_idx = 0, total_words = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_bad(int f);
    return (f >= 8) && (f % 3 == 1);
  endfunction

  logic inj;
  assign inj     = (wn == 4) && is_bad(frame_no);
  assign rx_word = tx_word ^ (inj ? (W'(1) << 7) : '0);

  ltp_framer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_flit_valid_i(flit_valid), .tx_flit_i(flit), .tx_flit_ready_o(ready),
    .tx_credit_i(credit),
    .tx_word_valid_o(wvalid), .tx_word_o(tx_word),
    .rx_word_valid_i(wvalid), .rx_word_i(rx_word),
    .rx_frame_valid_o(fvalid), .rx_crc_error_o(ferr),
    .rx_flits_o(rx_flits), .rx_credit_o(rx_credit)
  );

  function automatic logic [13:0] crc_ref(logic [1041:0] msg);
    logic [13:0] c = '1;
    for (int i = 1041; i >= 0; i--) begin
      logic fb = c[13] ^ msg[i];
      c = {c[12:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [1055:0] act, input logic [1055:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model of slot filling, sampled mid-cycle before the deciding edge
  always @(negedge clk) if (rst_n) begin
    if (ready && (flit_valid || acc_n != 0)) begin
      acc = {acc[1039-65:0], flit_valid ? flit : {1'b1, 64'h0}};
      acc_n++;
      if (acc_n == 16) begin
        exp_q.push_back({acc, credit, crc_ref({acc, credit})});
        acc_n = 0;
      end
    end
  end

  // transmit word collector
  always @(negedge clk) if (rst_n) begin
    if (wvalid) begin
      total_words++;
      wbuf = {wbuf[1055-W:0], tx_word};
      wn++;
      if (wn == NW) begin
        if (frame_no < exp_q.size()) begin
          chk(wbuf[1055:16] == exp_q[frame_no][1055:16], "R2/R11 frame flits", wbuf, exp_q[frame_no]);
          chk(wbuf[15:14] == exp_q[frame_no][15:14], "R6 credit field", wbuf[15:14], exp_q[frame_no][15:14]);
          chk(wbuf[13:0] == exp_q[frame_no][13:0], "R5 crc field", wbuf[13:0], exp_q[frame_no][13:0]);
          if (frame_no == 1)
            chk(wbuf[1055-10*65 -: 65] == {1'b1, 64'h0}, "R3 idle slot", wbuf[1055-10*65 -: 65], {1'b1, 64'h0});
        end else chk(0, "R2 unexpected frame", frame_no, exp_q.size());
        wn = 0;
        frame_no++;
      end
    end
  end

  // receive frame checker
  always @(negedge clk) if (rst_n) begin
    if (fvalid) begin
      if (rx_idx < exp_q.size()) begin
        chk(ferr == is_bad(rx_idx), "R10 crc error flag", ferr, is_bad(rx_idx));
        if (!is_bad(rx_idx)) begin
          chk(rx_flits == exp_q[rx_idx][1055:16], "R9 rx flits", rx_flits, exp_q[rx_idx][1055:16]);
          chk(rx_credit == exp_q[rx_idx][15:14], "R9 rx credit", rx_credit, exp_q[rx_idx][15:14]);
        end
      end else chk(0, "R9 unexpected rx frame", rx_idx, exp_q.size());
      rx_idx++;
    end
  end

  task automatic send(input logic [64:0] f);
    flit_valid = 1'b1;
    flit = f;
    do @(negedge clk); while (!ready);
    @(posedge clk); #1;
    flit_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(wvalid == 0, "R1 word valid in reset", wvalid, 0);
    chk(fvalid == 0, "R1 frame valid in reset", fvalid, 0);
    chk(ferr == 0, "R1 crc error in reset", ferr, 0);
    chk(ready == 1, "R1 ready in reset", ready, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    gap(1);
    chk(wvalid == 0 && ready == 1, "R1 after reset", {wvalid, ready}, 2'b01);

    gap(50);
    chk(total_words == 0, "R4 no words without flits", total_words, 0);

    // frame 0: full directed frame, mixed types
    credit = 2'b10;
    for (int i = 0; i < 16; i++) send({(i % 3 == 0), 32'hA5A5_0000 + 32'(i), 32'(i * 7)});
    @(negedge clk);
    chk(ready == 0, "R7 ready low after slot 15", ready, 0);
    @(negedge clk);
    chk(ready == 1, "R7 ready back after handoff", ready, 1);
    @(posedge clk); #1;

    // frame 1: three flits then idle fill
    credit = 2'b01;
    for (int i = 0; i < 3; i++) send({1'b0, 64'hC0DE_0000_0000_0000 + 64'(i)});
    gap(60);
    chk(frame_no == 2, "R3 short burst closed by idle fill", frame_no, 2);

    // random traffic with gaps and credit changes
    for (int n = 0; n < 1500; n++) begin
      credit = 2'($urandom);
      if ($urandom % 10 < 7) send({1'($urandom), $urandom, $urandom});
      else if ($urandom % 20 == 0) gap(30);
      else gap(1);
    end

    gap(300);
    chk(acc_n == 0, "R3 no partial frame left", acc_n, 0);
    chk(frame_no == exp_q.size(), "R2 all frames sent", frame_no, exp_q.size());
    chk(rx_idx == exp_q.size(), "R9 all frames received", rx_idx, exp_q.size());
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule